// File: doc/BRIEF.md
# Timer Output Pulse/Clock Shaper

This block sits behind a timer's period comparator. It turns the single-cycle period-match strobe into an output waveform. It also gives a status bit that software-facing logic can sample. A timer-clock enable marks the cycles on which the timer advances. Matches are honoured, and pulse widths are measured, only on those cycles.

The block has two modes. In pulse mode, each match drives the internal state high for one to four timer ticks, as set by a 2-bit width code. In clock mode, each match flips the internal state, which gives a square wave at half the match rate. The status output always shows the internal state without inversion. The pin output passes the same state through an inverter under its own control, so the pin can rest either high or low. Changing the mode clears the state at once, together with any pulse in progress.

Top module: `tmr_out_shaper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `stat_o` is 0 and `pin_o` equals `inv_i`.
- R2: In pulse mode (`mode_i`=0), a qualified match makes `stat_o` high for exactly `pw_i`+1 timer ticks (code 0→1, 1→2, 2→3, 3→4). The width code is latched at the match.
- R3: The state changes only on cycles where `tick_i` is 1. A match with `tick_i`=0 is ignored, and cycles with `tick_i`=0 do not shorten a pulse.
- R4: A qualified match that arrives while a pulse is still active restarts the width count from the new code.
- R5: In clock mode (`mode_i`=1), each qualified match inverts `stat_o` in the following cycle. Otherwise `stat_o` holds.
- R6: `pin_o` equals `stat_o` XOR `inv_i` in the same cycle, and `inv_i` has no effect on `stat_o`.
- R7: In a cycle where `mode_i` differs from its value in the previous cycle, `stat_o` reads 0. Any match in that cycle is ignored, and the state is 0 after the edge.
- R8: In pulse mode, with no match, the state returns to 0 and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer-clock enable; qualifies matches and width counting |
| match_i | input | 1 | Period-match strobe |
| mode_i | input | 1 | 0 = pulse mode, 1 = clock mode |
| pw_i | input | 2 | Pulse width code, width = code+1 ticks |
| inv_i | input | 1 | Pin inverter control |
| stat_o | output | 1 | Uninverted output state |
| pin_o | output | 1 | Output pin level |

## Verification
Directed runs measure the pulse length for each of the four width codes at one tick per cycle. They then repeat the measurement with the tick held off on some cycles, which separates counting by ticks from counting by clocks. A second match placed partway through a pulse tells a restart apart from a match that is ignored or extends the pulse. Back-to-back matches in clock mode tell a toggle apart from a set. Mode flips with a match in the same cycle show whether the clear takes priority. Random mixes of tick, match, mode, width and invert follow, each cycle compared against a bench reference model.

// File: rtl/tos_pkg.sv
package tos_pkg;
    localparam int unsigned PW_BITS = 2;

    typedef struct packed {
        logic               active;
        logic [PW_BITS-1:0] left;
    } pulse_st_t;

    typedef struct packed {
        logic level;
    } tog_st_t;

    typedef struct packed {
        logic mode;
    } top_st_t;
endpackage

// File: rtl/tos_pulse_gen.sv
module tos_pulse_gen
    import tos_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clear_i,
    input  logic               tick_i,
    input  logic               match_i,
    input  logic [PW_BITS-1:0] pw_i,
    output logic               active_o
);
    pulse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.active = 1'b0;
            st_d.left   = '0;
        end else if (tick_i && match_i) begin
            st_d.active = 1'b1;
            st_d.left   = pw_i;
        end else if (tick_i && st_q.active) begin
            if (st_q.left == '0) begin
                st_d.active = 1'b0;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign active_o = st_q.active;

    // R4: a qualified match always leaves the pulse active
    a_r4_match_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && match_i && !clear_i) |=> active_o);
    // R3: no tick means no change
    a_r3_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !clear_i) |=> $stable(active_o));
    // R8: never rises without a match
    a_r8_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(tick_i && match_i)) |=> !$rose(active_o));
endmodule

// File: rtl/tos_toggle.sv
module tos_toggle
    import tos_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic tick_i,
    input  logic match_i,
    output logic level_o
);
    tog_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i)                 st_d.level = 1'b0;
        else if (tick_i && match_i)  st_d.level = ~st_q.level;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign level_o = st_q.level;

    // R5: each qualified match inverts the level
    a_r5_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && match_i && !clear_i) |=> (level_o != $past(level_o)));
    // R5: otherwise the level holds
    a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(tick_i && match_i) && !clear_i) |=> $stable(level_o));
endmodule

// File: rtl/tos_pin_drive.sv
module tos_pin_drive #(
    parameter bit PIN_REG = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic state_i,
    input  logic inv_i,
    output logic pin_o
);
    generate
        if (PIN_REG) begin : g_reg
            logic pin_d, pin_q;
            always_comb pin_d = state_i ^ inv_i;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) pin_q <= 1'b0;
                else         pin_q <= pin_d;
            end
            assign pin_o = pin_q;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk_i ^ rst_ni;
            assign pin_o = state_i ^ inv_i;
        end
    endgenerate
endmodule

// File: rtl/tmr_out_shaper.sv
module tmr_out_shaper
    import tos_pkg::*;
#(
    parameter bit PIN_REG = 1'b0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_i,
    input  logic               match_i,
    input  logic               mode_i,
    input  logic [PW_BITS-1:0] pw_i,
    input  logic               inv_i,
    output logic               stat_o,
    output logic               pin_o
);
    top_st_t st_d, st_q;
    logic mode_chg, pulse_clr, tog_clr, pulse_lvl, tog_lvl;

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mode_chg  = (mode_i != st_q.mode);
    assign pulse_clr = mode_chg | mode_i;
    assign tog_clr   = mode_chg | ~mode_i;

    tos_pulse_gen i_pulse (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (pulse_clr),
        .tick_i   (tick_i),
        .match_i  (match_i),
        .pw_i     (pw_i),
        .active_o (pulse_lvl)
    );

    tos_toggle i_tog (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (tog_clr),
        .tick_i  (tick_i),
        .match_i (match_i),
        .level_o (tog_lvl)
    );

    assign stat_o = mode_i ? tog_lvl : pulse_lvl;

    tos_pin_drive #(.PIN_REG(PIN_REG)) i_pin (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .state_i (stat_o),
        .inv_i   (inv_i),
        .pin_o   (pin_o)
    );

    // R7: a mode change clears the state
    a_r7_mode_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_chg |-> !stat_o);
    a_r7_clear_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_chg |=> (!pulse_lvl && !tog_lvl));
    // R6: the idle generator stays cleared
    a_r6_one_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pulse_lvl && tog_lvl));
endmodule

// File: tb/test_tmr_out_shaper.sv
module test_tmr_out_shaper;
    logic clk = 1'b0, rst_n = 1'b0;
    logic tick = 0, match = 0, mode = 0, inv = 0;
    logic [1:0] pw = 0;
    logic stat, pin;
    int checks = 0, fails = 0;
    bit done = 0;
    logic m_mode = 0, m_state = 0;
    logic [1:0] m_left = 0;

    always #5 clk = ~clk;

    tmr_out_shaper i_tmr_out_shaper (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .match_i(match),
        .mode_i(mode), .pw_i(pw), .inv_i(inv), .stat_o(stat), .pin_o(pin));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_stat(input logic md);
        return (md != m_mode) ? 1'b0 : m_state;
    endfunction

    // one cycle: drive at negedge, check before edge, advance model
    task automatic step(input logic t, input logic m, input logic md,
                        input logic [1:0] w, input logic iv, input string req);
        logic e;
        tick = t; match = m; mode = md; pw = w; inv = iv;
        #1;
        e = exp_stat(md);
        chk(req, stat, e);
        chk("R6", pin, e ^ iv);
        if (md != m_mode) begin
            m_state = 0; m_left = 0; m_mode = md;
        end else if (!md) begin
            if (t && m) begin m_state = 1; m_left = w; end
            else if (t && m_state) begin
                if (m_left == 0) m_state = 0; else m_left = m_left - 1;
            end
        end else if (t && m) m_state = ~m_state;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int hi;
        void'($urandom(32'd7715));
        inv = 1;
        @(negedge clk); #1;
        chk("R1", stat, 1'b0); chk("R1", pin, 1'b1);
        @(negedge clk); rst_n = 1;
        #1; chk("R1", stat, 1'b0); chk("R1", pin, 1'b1);
        @(negedge clk);
        // R2: width codes at one tick per cycle, measured directly
        for (int w = 0; w < 4; w++) begin
            step(1, 1, 0, 2'(w), 0, "R2");
            hi = 0;
            for (int k = 0; k < 6; k++) begin
                #1; if (stat) hi++;
                step(1, 0, 0, 2'(3 - w), 0, "R2");
            end
            chk("R2 width", hi == w + 1, 1'b1);
        end
        // R3: gaps in tick stretch the pulse in clocks; unqualified match ignored
        step(0, 1, 0, 3, 0, "R3");
        step(1, 1, 0, 1, 1, "R3");
        for (int k = 0; k < 6; k++) step(k[0], 0, 0, 0, 1, "R3");
        // R4: restart mid-pulse
        step(1, 1, 0, 2, 0, "R4");
        step(1, 0, 0, 0, 0, "R4");
        step(1, 1, 0, 3, 0, "R4");
        for (int k = 0; k < 6; k++) step(1, 0, 0, 0, 0, "R4");
        // R7: mode change with match in the same cycle
        step(1, 1, 0, 3, 0, "R7");
        step(1, 1, 1, 0, 0, "R7");
        // R5: toggling, back-to-back and with holds
        for (int k = 0; k < 8; k++) step(1, k < 4 || k[0], 1, 0, k[1], "R5");
        step(0, 1, 1, 0, 0, "R5");
        step(1, 1, 0, 0, 1, "R7");
        step(1, 0, 0, 0, 1, "R8");
        for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, "R8");
        // random mix
        for (int k = 0; k < 3000; k++)
            step(1'($urandom), ($urandom % 4) == 0, ($urandom % 40) == 0 ? ~mode : mode,
                 2'($urandom), 1'($urandom), "R2/R5 random");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule